// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the control and cumulative status state shared by a floating-point datapath. Software reads and writes it as one 32-bit word holding a rounding-mode field, a flush-to-zero control, a default-NaN control, five cumulative exception flags and an input-denormal flag. The arithmetic units never clear this state. Each unit reports a completed operation with a one-cycle strobe and a vector of exception indications, and the block ORs them into the sticky flags. While doing so it drops an inexact indication that came together with underflow while flush-to-zero is on.

The block also computes, combinationally, the rounding mode that an operation about to issue must use. The register field is the default. An operation may name its own mode for that operation alone. A force-toward-zero request beats both. The flush-to-zero and default-NaN controls are brought out as plain levels for the datapath.

Top module: `fp_status_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the read word is 0x00000000, the effective rounding mode is 0 (to nearest), and both the flush and default-NaN outputs are low.
- R2: When `op_done` is high, each set bit among `op_exc[4:0]` sets the matching flag: invalid at bit 0, divide-by-zero at bit 1, overflow at bit 2, underflow at bit 3, inexact at bit 4. An operation completion never clears a flag.
- R3: When `op_done` is high and `op_exc[5]` (input operand flushed) is set, register bit 7 becomes 1 and stays set.
- R4: When flush-to-zero (register bit 24) is 1 and a completion reports both underflow (`op_exc[3]`) and inexact (`op_exc[4]`), bit 4 is not set by that completion. Underflow is still recorded.
- R5: A software write replaces the whole register one cycle later, clearing flags if written as 0. Only bits 0-4, 7, 22-25 are stored, and every other bit reads as 0.
- R6: When a write and a completion fall in the same cycle, the register takes the masked written value ORed with the completion's filtered flag bits. The inexact filtering uses the flush-to-zero value held before the write.
- R7: The rounding-mode field is bits 23:22 (0 nearest, 1 toward +infinity, 2 toward -infinity, 3 toward zero). With no override and no force request, `eff_rm` equals this field in the same cycle.
- R8: When `rm_ovr_en` is high and `force_rz` is low, `eff_rm` equals `rm_ovr` in that cycle, and the register contents are not changed by it.
- R9: When `force_rz` is high, `eff_rm` is 3 (toward zero) whatever the field and the override.
- R10: When `op_done` is low, `op_exc` has no effect on the register.
- R11: `ctl_fz` equals register bit 24 and `ctl_dn` equals register bit 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current register contents |
| op_done | input | 1 | Operation-complete strobe |
| op_exc | input | 6 | Exception indications of the completing operation |
| rm_ovr_en | input | 1 | Operation supplies its own rounding mode |
| rm_ovr | input | 2 | Operation's rounding mode |
| force_rz | input | 1 | Force rounding toward zero |
| eff_rm | output | 2 | Effective rounding mode for the current operation |
| ctl_fz | output | 1 | Flush-to-zero control |
| ctl_dn | output | 1 | Default-NaN control |

## Verification
A software write and an operation completion can land in the same cycle. The bench provokes this both in directed steps and in a long random phase, where it drives `sw_we` and `op_done` together with exception vectors that include underflow plus inexact under both flush settings. Each step's expected word is computed by a behavioural model as the masked write data ORed with the filtered flags, using the flush bit from before the write. That word is compared with `sw_rdata` one cycle later, and the combinational rounding mode is compared in the issuing cycle.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    localparam int REG_W      = 32;
    localparam int EXC_W      = 6;
    localparam int NUM_CUM    = 5;
    localparam int RM_W       = 2;

    localparam int POS_INV    = 0;
    localparam int POS_DZ     = 1;
    localparam int POS_OVF    = 2;
    localparam int POS_UNF    = 3;
    localparam int POS_INX    = 4;
    localparam int POS_IDN    = 7;
    localparam int POS_RM_LO  = 22;
    localparam int POS_FZ     = 24;
    localparam int POS_DN     = 25;

    localparam logic [REG_W-1:0] STORE_MASK =
        (REG_W'(1) << POS_INV) | (REG_W'(1) << POS_DZ) | (REG_W'(1) << POS_OVF) |
        (REG_W'(1) << POS_UNF) | (REG_W'(1) << POS_INX) | (REG_W'(1) << POS_IDN) |
        (REG_W'(3) << POS_RM_LO) | (REG_W'(1) << POS_FZ) | (REG_W'(1) << POS_DN);

    typedef enum logic [RM_W-1:0] {
        RM_NEAREST = 2'd0,
        RM_POS_INF = 2'd1,
        RM_NEG_INF = 2'd2,
        RM_ZERO    = 2'd3
    } rmode_e;

    // Exception vector of one completing operation; invalid is bit 0.
    typedef struct packed {
        logic denorm_in;
        logic inexact;
        logic underflow;
        logic overflow;
        logic divzero;
        logic invalid;
    } exc_t;

    typedef struct packed {
        logic   dn;
        logic   fz;
        rmode_e rm;
    } ctl_t;

    // Register bit position of cumulative flag k.
    function automatic int cum_pos(input int k);
        case (k)
            0: cum_pos = POS_INV;
            1: cum_pos = POS_DZ;
            2: cum_pos = POS_OVF;
            3: cum_pos = POS_UNF;
            default: cum_pos = POS_INX;
        endcase
    endfunction

    function automatic ctl_t decode_ctl(input logic [REG_W-1:0] word);
        ctl_t c;
        c.dn = word[POS_DN];
        c.fz = word[POS_FZ];
        c.rm = rmode_e'(word[POS_RM_LO +: RM_W]);
        return c;
    endfunction

endpackage

// File: rtl/fpsr_exc_filter.sv
module fpsr_exc_filter
    import fpsr_pkg::*;
(
    input  logic             valid,
    input  exc_t             exc,
    input  logic             fz,
    output logic [REG_W-1:0] set_bits
);
    logic [NUM_CUM-1:0] cum_raw;
    logic [NUM_CUM-1:0] cum_kept;
    logic               drop_inexact;

    assign cum_raw      = {exc.inexact, exc.underflow, exc.overflow, exc.divzero, exc.invalid};
    assign drop_inexact = fz && exc.underflow;

    always_comb begin
        cum_kept = cum_raw;
        if (drop_inexact) begin
            cum_kept[NUM_CUM-1] = 1'b0;
        end
    end

    logic [REG_W-1:0] lane [NUM_CUM+1];

    assign lane[0] = valid && exc.denorm_in ? (REG_W'(1) << POS_IDN) : '0;

    for (genvar k = 0; k < NUM_CUM; k++) begin : g_flag
        localparam int P = cum_pos(k);
        assign lane[k+1] = lane[k] | ((valid && cum_kept[k]) ? (REG_W'(1) << P) : '0);
    end

    assign set_bits = lane[NUM_CUM];

endmodule

// File: rtl/fpsr_rm_select.sv
module fpsr_rm_select
    import fpsr_pkg::*;
(
    input  rmode_e reg_rm,
    input  logic   ovr_en,
    input  rmode_e ovr_rm,
    input  logic   force_rz,
    output rmode_e eff_rm
);
    always_comb begin
        if (force_rz) begin
            eff_rm = RM_ZERO;
        end else if (ovr_en) begin
            eff_rm = ovr_rm;
        end else begin
            eff_rm = reg_rm;
        end
    end
endmodule

// File: rtl/fpsr_state.sv
module fpsr_state
    import fpsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] set_bits,
    output logic [REG_W-1:0] q
);
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] nxt;

    always_comb begin
        base = we ? (wdata & STORE_MASK) : q;
        nxt  = base | (set_bits & STORE_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
    import fpsr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_we,
    input  logic [31:0] sw_wdata,
    output logic [31:0] sw_rdata,
    input  logic        op_done,
    input  logic [5:0]  op_exc,
    input  logic        rm_ovr_en,
    input  logic [1:0]  rm_ovr,
    input  logic        force_rz,
    output logic [1:0]  eff_rm,
    output logic        ctl_fz,
    output logic        ctl_dn
);
    logic [REG_W-1:0] reg_q;
    logic [REG_W-1:0] set_bits;
    ctl_t             ctl;
    rmode_e           rm_sel;

    assign ctl = decode_ctl(reg_q);

    fpsr_exc_filter u_filter (
        .valid    (op_done),
        .exc      (exc_t'(op_exc)),
        .fz       (ctl.fz),
        .set_bits (set_bits)
    );

    fpsr_state u_state (
        .clk      (clk),
        .rst      (rst),
        .we       (sw_we),
        .wdata    (sw_wdata),
        .set_bits (set_bits),
        .q        (reg_q)
    );

    fpsr_rm_select u_rm (
        .reg_rm   (ctl.rm),
        .ovr_en   (rm_ovr_en),
        .ovr_rm   (rmode_e'(rm_ovr)),
        .force_rz (force_rz),
        .eff_rm   (rm_sel)
    );

    assign sw_rdata = reg_q;
    assign eff_rm   = rm_sel;
    assign ctl_fz   = ctl.fz;
    assign ctl_dn   = ctl.dn;

endmodule

// File: rtl/fp_status_ctrl_chk.sv
module fp_status_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        sw_we,
    input logic [31:0] sw_wdata,
    input logic [31:0] sw_rdata,
    input logic        op_done,
    input logic [5:0]  op_exc,
    input logic        rm_ovr_en,
    input logic [1:0]  rm_ovr,
    input logic        force_rz,
    input logic [1:0]  eff_rm,
    input logic        ctl_fz
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (sw_rdata == 32'h0)); // R1
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !sw_we |=> ((sw_rdata[4:0] & $past(sw_rdata[4:0])) == $past(sw_rdata[4:0]))); // R2
    AST_IDN_SETS: assert property (@(posedge clk) disable iff (rst)
        (op_done && op_exc[5]) |=> sw_rdata[7]); // R3
    AST_INEXACT_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
        (op_done && !sw_we && ctl_fz && op_exc[3] && !sw_rdata[4]) |=> !sw_rdata[4]); // R4
    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        (sw_we && !op_done) |=> (sw_rdata == ($past(sw_wdata) & 32'h03C0009F))); // R5
    AST_OVERRIDE_MODE: assert property (@(posedge clk) disable iff (rst)
        (rm_ovr_en && !force_rz) |-> (eff_rm == rm_ovr)); // R8
    AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (rst)
        force_rz |-> (eff_rm == 2'd3)); // R9
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!op_done && !sw_we) |=> $stable(sw_rdata)); // R10
endmodule

bind fp_status_ctrl fp_status_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sw_we     (sw_we),
    .sw_wdata  (sw_wdata),
    .sw_rdata  (sw_rdata),
    .op_done   (op_done),
    .op_exc    (op_exc),
    .rm_ovr_en (rm_ovr_en),
    .rm_ovr    (rm_ovr),
    .force_rz  (force_rz),
    .eff_rm    (eff_rm),
    .ctl_fz    (ctl_fz)
);

// File: tb/fp_status_ctrl_tb.sv
`timescale 1ns/1ps
module fp_status_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        sw_we;
    logic [31:0] sw_wdata;
    logic [31:0] sw_rdata;
    logic        op_done;
    logic [5:0]  op_exc;
    logic        rm_ovr_en;
    logic [1:0]  rm_ovr;
    logic        force_rz;
    logic [1:0]  eff_rm;
    logic        ctl_fz;
    logic        ctl_dn;

    always #4 clk = ~clk;

    fp_status_ctrl u_dut (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .op_done(op_done), .op_exc(op_exc), .rm_ovr_en(rm_ovr_en), .rm_ovr(rm_ovr),
        .force_rz(force_rz), .eff_rm(eff_rm), .ctl_fz(ctl_fz), .ctl_dn(ctl_dn)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit [31:0] model = 32'h0;
    localparam bit [31:0] KEEP = 32'h03C0009F;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock step: drive at negedge, check combinational outputs, then the register after the edge.
    task automatic step(input string req, input bit we, input bit [31:0] wd, input bit done,
                        input bit [5:0] exc, input bit oen, input bit [1:0] orm, input bit frz);
        bit [31:0] setv;
        bit [1:0]  exp_rm;
        sw_we = we; sw_wdata = wd; op_done = done; op_exc = exc;
        rm_ovr_en = oen; rm_ovr = orm; force_rz = frz;
        #1;
        exp_rm = frz ? 2'd3 : (oen ? orm : model[23:22]);
        check(req, "eff_rm", eff_rm, exp_rm);
        setv = 32'h0;
        if (done) begin
            setv[3:0] = exc[3:0];
            setv[4] = exc[4] && !(exc[3] && model[24]);
            setv[7] = exc[5];
        end
        model = (we ? (wd & KEEP) : model) | setv;
        @(negedge clk);
        check(req, "rdata", sw_rdata, model);
        check("R11", "fz", ctl_fz, model[24]);
        check("R11", "dn", ctl_dn, model[25]);
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sw_we = 0; sw_wdata = 0; op_done = 0; op_exc = 0;
        rm_ovr_en = 0; rm_ovr = 0; force_rz = 0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "rdata", sw_rdata, 0);
        check("R1", "eff_rm", eff_rm, 0);
        check("R1", "fz", ctl_fz, 0);
        // R2 each flag, sticky
        step("R2", 0, 0, 1, 6'b000001, 0, 0, 0);
        step("R2", 0, 0, 1, 6'b000110, 0, 0, 0);
        step("R2", 0, 0, 1, 6'b000000, 0, 0, 0);
        step("R2", 0, 0, 1, 6'b011000, 0, 0, 0);
        // R3 input denormal
        step("R3", 0, 0, 1, 6'b100000, 0, 0, 0);
        // R10 exc ignored without strobe
        step("R5", 1, 32'h0, 0, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 6'b111111, 0, 0, 0);
        // R5 write all ones, reserved bits read zero; then clear
        step("R5", 1, 32'hFFFFFFFF, 0, 0, 0, 0, 0);
        step("R5", 1, 32'h0, 0, 0, 0, 0, 0);
        // R4 suppression under flush-to-zero
        step("R5", 1, 32'h01000000, 0, 0, 0, 0, 0);
        step("R4", 0, 0, 1, 6'b011000, 0, 0, 0);
        step("R4", 0, 0, 1, 6'b010000, 0, 0, 0);
        step("R5", 1, 32'h0, 0, 0, 0, 0, 0);
        step("R4", 0, 0, 1, 6'b011000, 0, 0, 0);
        // R6 write plus completion, filter uses old fz
        step("R6", 1, 32'h01000000, 1, 6'b011000, 0, 0, 0);
        step("R6", 1, 32'h02000000, 1, 6'b011001, 0, 0, 0);
        // R7 register modes
        for (int m = 0; m < 4; m++) begin
            step("R5", 1, 32'(m) << 22, 0, 0, 0, 0, 0);
            step("R7", 0, 0, 0, 0, 0, 0, 0);
        end
        // R8 override, register unchanged
        step("R5", 1, 32'h00400000, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 1, 6'b000100, 1, 2'd2, 0);
        step("R8", 0, 0, 0, 0, 1, 2'd0, 0);
        step("R7", 0, 0, 0, 0, 0, 0, 0);
        // R9 force beats override and field
        step("R9", 0, 0, 0, 0, 1, 2'd1, 1);
        step("R9", 0, 0, 0, 0, 0, 2'd0, 1);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit [31:0] r;
            r = $urandom;
            step("R6", r[0] && r[1], $urandom, r[2], 6'($urandom), r[3], r[5:4], r[6] && r[7]);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule